// File: doc/BRIEF.md
# Event Timer Comparator Channel

One comparator channel of a multi-channel event timer. It watches a free-running main counter, supplied from outside, and issues a single-cycle fire strobe when the counter reaches the channel's comparator. A register decoder outside the block writes three things into the channel: a small configuration word, and comparator values in two halves (low and high). The channel keeps its comparator, a hidden period register and its configuration. It reports the comparator, the period, the configuration with two read-only capability bits, and whether the interrupt is level or edge type.

The channel runs in one-shot or periodic mode, over the full counter width or over the low half only. In periodic mode it moves the comparator forward by the period after each match. If the comparator is still at or behind the counter after an add, it keeps adding, one add per clock, until the comparator is ahead. A one-shot SETVAL-style flag lets software load the comparator directly while the channel is in periodic mode. In half-width one-shot mode, the channel also fires when the counter's low half passes all ones, if that wrap comes before the match.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator is all ones and the period is zero. The fire strobe and wrap-pending output are low. The configuration readback is 7'b1100000: bit 6 (full-width capable) and bit 5 (periodic capable) are constant ones, and bits 4:0 are zero.
- R2: In one-shot mode with the channel enabled, a counter value equal to the comparator, presented at a clock edge, drives fire_o high for exactly the following cycle. The comparator is left unchanged.
- R3: The configuration write data uses bit 0 for enable, bit 1 for periodic, bit 2 for level type, bit 3 for half-width mode and bit 4 for the load flag. In one-shot mode, or when the load flag is set, a low-half write replaces comparator bits H-1:0 and a high-half write replaces bits W-1:H. In periodic mode a low-half write also replaces the low half of the period. A high-half write with the load flag clear replaces only the period's high half.
- R4: Any comparator half write clears the load flag (configuration bit 4).
- R5: A value stored into the period has its top bit forced to zero: bit H-1 of a low-half write in half-width mode, and bit W-1 (the top of a high-half write) in full-width mode.
- R6: In periodic mode with a non-zero period, each match fires and adds the period to the comparator, so the channel fires once per period.
- R7: While periodic, enabled and with a non-zero period, a comparator at or behind the counter gets the period added once per clock, until the comparator is ahead. "Behind" means the difference comparator minus counter, taken over the active width, is zero or negative. No strobe fires unless a comparator value equals the counter.
- R8: Writing the configuration with the half-width bit set clears the upper halves of the comparator and the period. In half-width mode, high-half writes are ignored and equality compares only the low halves of counter and comparator.
- R9: In half-width periodic mode the comparator plus period sum is truncated to H bits.
- R10: In half-width one-shot mode, when arming (enable rising, or any comparator write) finds the comparator's low half numerically below the counter's low half, a wrap flag is set. The channel then fires when the counter's low half is all ones, and the flag clears. The later match fires as usual.
- R11: A disabled channel never fires. Enabling again re-arms it, so the next match fires.
- R12: A one-shot match fires once, even if the counter stays at the matching value.
- R13: level_o follows configuration bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| count_i | input | CNT_W | Main counter value |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | Configuration write data |
| cmp_lo_wr_i | input | 1 | Comparator low-half write strobe |
| cmp_hi_wr_i | input | 1 | Comparator high-half write strobe |
| cmp_wdata_i | input | CNT_W/2 | Comparator half write data |
| fire_o | output | 1 | One-cycle fire strobe |
| level_o | output | 1 | Interrupt is level type |
| cfg_o | output | 7 | Configuration readback with capability bits |
| cmp_o | output | CNT_W | Comparator value |
| period_o | output | CNT_W | Hidden period value |
| wrap_pend_o | output | 1 | Half-width wrap event pending |

## Verification
The properties assume the decoder never raises a configuration write in the same cycle as a comparator write. Under that assumption, a cycle with no write is one in which only the periodic add can change the comparator. The stimulus issues each write alone in its own cycle. It moves the counter only by single increments or by loads made while no match is expected in the middle of the jump. The scoreboard keys each expected strobe to a counter value rather than a cycle number, so the moment a counter start or stop takes effect does not change any expected result.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
   localparam int CFG_WR_W = 5;
   localparam int CFG_RD_W = 7;

   typedef struct packed {
      logic setval;
      logic half;
      logic level;
      logic periodic;
      logic enable;
   } chan_cfg_t;
endpackage

// File: rtl/evt_cmp_regs.sv
module evt_cmp_regs
   import evt_cmp_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   cfg_wr_i,
   input  logic [CFG_WR_W-1:0]    cfg_wdata_i,
   input  logic                   cmp_lo_wr_i,
   input  logic                   cmp_hi_wr_i,
   input  logic [CNT_W/2-1:0]     cmp_wdata_i,
   input  logic                   add_en_i,
   output chan_cfg_t              cfg_o,
   output logic [CNT_W-1:0]       cmp_o,
   output logic [CNT_W-1:0]       period_o,
   output logic                   arm_o
);
   localparam int H = CNT_W / 2;

   chan_cfg_t        cfg_q;
   chan_cfg_t        cfg_new;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] full_sum;
   logic [CNT_W-1:0] sum;
   logic             cmp_sel;
   logic [1:0]       cmp_hw;
   logic [1:0]       per_hw;
   logic [H-1:0]     per_val [2];

   assign cfg_new = chan_cfg_t'(cfg_wdata_i);
   assign cmp_sel = !cfg_q.periodic || cfg_q.setval;

   // Per-half write steering: half 0 is the low word, half 1 the high word.
   for (genvar g = 0; g < 2; g++) begin : g_half
      logic sel;
      logic top_clr;
      if (g == 0) begin : g_lo
         assign sel     = cmp_lo_wr_i;
         assign top_clr = cfg_q.half;
      end else begin : g_hi
         assign sel     = cmp_hi_wr_i && !cfg_q.half;
         assign top_clr = 1'b1;
      end
      assign cmp_hw[g]  = sel && cmp_sel;
      assign per_hw[g]  = sel && cfg_q.periodic && ((g == 0) || !cfg_q.setval);
      assign per_val[g] = {cmp_wdata_i[H-1] && !top_clr, cmp_wdata_i[H-2:0]};
   end

   assign full_sum = cmp_q + per_q;
   assign sum      = cfg_q.half ? {{H{1'b0}}, full_sum[H-1:0]} : full_sum;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q <= '0;
         cmp_q <= '1;
         per_q <= '0;
         arm_o <= 1'b0;
      end else begin
         arm_o <= 1'b0;
         if (cfg_wr_i) begin
            cfg_q <= cfg_new;
            if (cfg_new.half) begin
               cmp_q[CNT_W-1:H] <= '0;
               per_q[CNT_W-1:H] <= '0;
            end
            arm_o <= cfg_new.enable && !cfg_q.enable;
         end else if (cmp_lo_wr_i || cmp_hi_wr_i) begin
            cfg_q.setval <= 1'b0;
            arm_o        <= 1'b1;
            if (cmp_hw[0]) cmp_q[H-1:0]     <= cmp_wdata_i;
            if (cmp_hw[1]) cmp_q[CNT_W-1:H] <= cmp_wdata_i;
            if (per_hw[0]) per_q[H-1:0]     <= per_val[0];
            if (per_hw[1]) per_q[CNT_W-1:H] <= per_val[1];
         end else if (add_en_i) begin
            cmp_q <= sum;
         end
      end
   end

   assign cfg_o    = cfg_q;
   assign cmp_o    = cmp_q;
   assign period_o = per_q;
endmodule

// File: rtl/evt_cmp_match.sv
module evt_cmp_match
   import evt_cmp_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] count_i,
   input  chan_cfg_t        cfg_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             arm_i,
   output logic             add_en_o,
   output logic             fire_o,
   output logic             wrap_o
);
   localparam int H = CNT_W / 2;

   logic [CNT_W-1:0] diff;
   logic             eq;
   logic             behind;
   logic             wrap_hit;
   logic             hit;
   logic             hit_q;
   logic             moved_q;
   logic             wrap_q;

   assign diff = cmp_i - count_i;

   always_comb begin
      if (cfg_i.half) begin
         eq     = cmp_i[H-1:0] == count_i[H-1:0];
         behind = diff[H-1] || (diff[H-1:0] == '0);
      end else begin
         eq     = cmp_i == count_i;
         behind = diff[CNT_W-1] || (diff == '0);
      end
   end

   assign add_en_o = cfg_i.enable && cfg_i.periodic && (|period_i) && behind;
   assign wrap_hit = wrap_q && (&count_i[H-1:0]);
   assign hit      = cfg_i.enable && (eq || wrap_hit);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hit_q   <= 1'b0;
         moved_q <= 1'b0;
         fire_o  <= 1'b0;
         wrap_q  <= 1'b0;
      end else begin
         hit_q   <= hit;
         moved_q <= add_en_o;
         fire_o  <= hit && (!hit_q || moved_q);
         if (!cfg_i.enable) begin
            wrap_q <= 1'b0;
         end else if (arm_i) begin
            wrap_q <= cfg_i.half && !cfg_i.periodic && (cmp_i[H-1:0] < count_i[H-1:0]);
         end else if (wrap_hit) begin
            wrap_q <= 1'b0;
         end
      end
   end

   assign wrap_o = wrap_q;
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
   import evt_cmp_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [CNT_W-1:0]     count_i,
   input  logic                 cfg_wr_i,
   input  logic [CFG_WR_W-1:0]  cfg_wdata_i,
   input  logic                 cmp_lo_wr_i,
   input  logic                 cmp_hi_wr_i,
   input  logic [CNT_W/2-1:0]   cmp_wdata_i,
   output logic                 fire_o,
   output logic                 level_o,
   output logic [CFG_RD_W-1:0]  cfg_o,
   output logic [CNT_W-1:0]     cmp_o,
   output logic [CNT_W-1:0]     period_o,
   output logic                 wrap_pend_o
);
   if ((CNT_W % 2) != 0 || CNT_W < 8) begin : g_bad_width
      $error("evt_cmp_channel: CNT_W must be even and at least 8");
   end

   chan_cfg_t        cfg;
   logic [CNT_W-1:0] cmp;
   logic [CNT_W-1:0] per;
   logic             arm;
   logic             add_en;

   evt_cmp_regs #(.CNT_W(CNT_W)) regs_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_wr_i    (cfg_wr_i),
      .cfg_wdata_i (cfg_wdata_i),
      .cmp_lo_wr_i (cmp_lo_wr_i),
      .cmp_hi_wr_i (cmp_hi_wr_i),
      .cmp_wdata_i (cmp_wdata_i),
      .add_en_i    (add_en),
      .cfg_o       (cfg),
      .cmp_o       (cmp),
      .period_o    (per),
      .arm_o       (arm)
   );

   evt_cmp_match #(.CNT_W(CNT_W)) match_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .count_i  (count_i),
      .cfg_i    (cfg),
      .cmp_i    (cmp),
      .period_i (per),
      .arm_i    (arm),
      .add_en_o (add_en),
      .fire_o   (fire_o),
      .wrap_o   (wrap_pend_o)
   );

   assign cfg_o    = {2'b11, cfg};
   assign level_o  = cfg.level;
   assign cmp_o    = cmp;
   assign period_o = per;
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
   parameter int CNT_W = 64
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cfg_wr_i,
   input logic             cmp_lo_wr_i,
   input logic             cmp_hi_wr_i,
   input logic [6:0]       cfg_o,
   input logic [CNT_W-1:0] cmp_o,
   input logic [CNT_W-1:0] period_o,
   input logic             fire_o
);
   localparam int H = CNT_W / 2;

   AST_SETVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_lo_wr_i || cmp_hi_wr_i) && !cfg_wr_i |=> !cfg_o[4]); // R4

   AST_PERIOD_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !period_o[CNT_W-1]); // R5

   AST_HALF_PERIOD_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[3] && cfg_o[1] && cmp_lo_wr_i && !cfg_wr_i |=> !period_o[H-1]); // R5

   AST_HALF_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[3] |-> (cmp_o[CNT_W-1:H] == '0) && (period_o[CNT_W-1:H] == '0)); // R8

   AST_ONESHOT_CMP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_o[1] && !cfg_wr_i && !cmp_lo_wr_i && !cmp_hi_wr_i |=> $stable(cmp_o)); // R2

   AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_o[0] |=> !fire_o); // R11
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CNT_W(CNT_W)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cfg_wr_i    (cfg_wr_i),
   .cmp_lo_wr_i (cmp_lo_wr_i),
   .cmp_hi_wr_i (cmp_hi_wr_i),
   .cfg_o       (cfg_o),
   .cmp_o       (cmp_o),
   .period_o    (period_o),
   .fire_o      (fire_o)
);

// File: tb/evt_cmp_channel_tb_top.sv
module evt_cmp_channel_tb_top;
   localparam int W = 64;
   localparam logic [4:0] EN = 5'd1, PER = 5'd2, LVL = 5'd4, HALF = 5'd8, SETV = 5'd16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  count = '0;
   logic          cfg_wr = 1'b0;
   logic [4:0]    cfg_wdata = '0;
   logic          lo_wr = 1'b0;
   logic          hi_wr = 1'b0;
   logic [W/2-1:0] wdata = '0;
   logic          fire, level, wrap_pend;
   logic [6:0]    cfg_rd;
   logic [W-1:0]  cmp_rd, per_rd;

   int            nchk = 0;
   int            nerr = 0;
   bit            done = 1'b0;
   bit            run = 1'b0;
   bit            ld_req = 1'b0;
   logic [W-1:0]  ld_val = '0;
   logic [W-1:0]  exp_q[$];
   string         tag_q[$];

   always #5 clk = ~clk;

   evt_cmp_channel #(.CNT_W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .count_i(count),
      .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
      .cmp_lo_wr_i(lo_wr), .cmp_hi_wr_i(hi_wr), .cmp_wdata_i(wdata),
      .fire_o(fire), .level_o(level), .cfg_o(cfg_rd),
      .cmp_o(cmp_rd), .period_o(per_rd), .wrap_pend_o(wrap_pend)
   );

   // Monitor and counter driver: at each falling edge, compare any strobe
   // against the counter value that the preceding rising edge saw.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && fire) begin
            nchk++;
            if (exp_q.size() == 0) begin
               nerr++;
               $display("FAIL R12 unexpected fire at count %h, expected none", count);
            end else begin
               logic [W-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (count !== e) begin
                  nerr++;
                  $display("FAIL %s fire at count %h, expected %h", t, count, e);
               end
            end
         end
         if (ld_req) begin
            count  = ld_val;
            ld_req = 1'b0;
         end else if (run) begin
            count = count + 1'b1;
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr_cfg(input logic [4:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic wr_lo(input logic [W/2-1:0] v);
      @(negedge clk); lo_wr = 1'b1; wdata = v;
      @(negedge clk); lo_wr = 1'b0;
   endtask

   task automatic wr_hi(input logic [W/2-1:0] v);
      @(negedge clk); hi_wr = 1'b1; wdata = v;
      @(negedge clk); hi_wr = 1'b0;
   endtask

   task automatic load(input logic [W-1:0] v);
      run = 1'b0;
      ld_val = v;
      ld_req = 1'b1;
      tick(3);
   endtask

   task automatic expect_fire(input logic [W-1:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 cmp", cmp_rd, '1);
      chk("R1 period", per_rd, '0);
      chk("R1 cfg", {57'd0, cfg_rd}, 64'h60);
      chk("R1 fire/wrap", {62'd0, fire, wrap_pend}, '0);

      // R13 level type bit
      wr_cfg(LVL);
      chk("R13 level", {63'd0, level}, 64'd1);
      chk("R13 cfg", {57'd0, cfg_rd}, 64'h64);

      // R2 one-shot full-width match, R12 single strobe
      wr_cfg(5'd0);
      wr_lo(32'd20);
      wr_hi(32'd0);
      chk("R3 oneshot cmp write", cmp_rd, 64'd20);
      load(64'd0);
      expect_fire(64'd20, "R2");
      wr_cfg(EN);
      run = 1'b1;
      tick(30);
      run = 1'b0;
      chk("R2 cmp unchanged", cmp_rd, 64'd20);

      // R3 R4 R6 periodic
      wr_cfg(PER | SETV);
      wr_lo(32'd100);
      chk("R4 setval cleared", {63'd0, cfg_rd[4]}, 64'd0);
      wr_hi(32'd0);
      chk("R3 periodic cmp", cmp_rd, 64'd100);
      chk("R3 periodic period", per_rd, 64'd100);
      load(64'd90);
      expect_fire(64'd100, "R6");
      expect_fire(64'd200, "R6");
      expect_fire(64'd300, "R6");
      wr_cfg(EN | PER);
      run = 1'b1;
      tick(215);
      run = 1'b0;
      tick(2);
      chk("R6 cmp after three periods", cmp_rd, 64'd400);

      // R7 catch-up with counter held ahead
      load(64'd1050);
      tick(12);
      chk("R7 caught-up cmp", cmp_rd, 64'd1100);
      expect_fire(64'd1100, "R7");
      run = 1'b1;
      tick(60);
      run = 1'b0;
      tick(2);

      // R5 R3 period masking and steering
      wr_cfg(PER | HALF);
      wr_lo(32'hFFFF_FFFF);
      chk("R5 half-mode period mask", per_rd, 64'h7FFF_FFFF);
      chk("R3 cmp kept on period write", cmp_rd, 64'd1200);
      wr_cfg(PER);
      wr_hi(32'hFFFF_FFFF);
      chk("R5 full-mode period mask", per_rd, 64'h7FFF_FFFF_7FFF_FFFF);
      chk("R3 hi write period only", cmp_rd, 64'd1200);
      wr_cfg(PER | SETV);
      wr_hi(32'h12);
      chk("R3 setval hi write", cmp_rd, 64'h12_0000_04B0);
      chk("R3 setval hi keeps period", per_rd, 64'h7FFF_FFFF_7FFF_FFFF);
      chk("R4 setval cleared hi", {63'd0, cfg_rd[4]}, 64'd0);

      // R8 half-width truncation and ignored high writes
      wr_cfg(5'd0);
      wr_hi(32'hABCD);
      chk("R3 oneshot hi write", cmp_rd, 64'hABCD_0000_04B0);
      wr_cfg(HALF);
      chk("R8 cmp truncated", cmp_rd, 64'h4B0);
      chk("R8 period truncated", per_rd, 64'h7FFF_FFFF);
      wr_hi(32'h55);
      chk("R8 hi write ignored", cmp_rd, 64'h4B0);

      // R10 wrap event in half-width one-shot
      load(64'hFFFF_FFF0);
      wr_lo(32'd5);
      wr_cfg(EN | HALF);
      tick(3);
      chk("R10 wrap pending", {63'd0, wrap_pend}, 64'd1);
      expect_fire(64'hFFFF_FFFF, "R10 wrap");
      expect_fire(64'h1_0000_0005, "R10 match");
      run = 1'b1;
      tick(30);
      run = 1'b0;
      tick(2);
      chk("R10 wrap cleared", {63'd0, wrap_pend}, 64'd0);
      wr_cfg(HALF);

      // R9 half-width periodic sum truncation, upper counter ignored
      wr_cfg(PER | SETV | HALF);
      wr_lo(32'hFFFF_FF00);
      wr_lo(32'h100);
      chk("R9 period set", per_rd, 64'h100);
      load(64'h2_FFFF_FF00);
      expect_fire(64'h2_FFFF_FF00, "R9");
      wr_cfg(EN | PER | HALF);
      tick(6);
      chk("R9 truncated sum", cmp_rd, 64'd0);
      wr_cfg(5'd0);

      // R11 disable suppresses, re-enable re-arms
      load(64'd40);
      wr_lo(32'd50);
      wr_cfg(EN);
      run = 1'b1;
      tick(4);
      wr_cfg(5'd0);
      tick(14);
      run = 1'b0;
      chk("R11 cmp kept while disabled", cmp_rd, 64'd50);
      load(64'd40);
      expect_fire(64'd50, "R11 re-armed");
      wr_cfg(EN);
      run = 1'b1;
      tick(20);
      run = 1'b0;
      tick(3);

      while (exp_q.size() != 0) begin
         logic [W-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         nchk++;
         nerr++;
         $display("FAIL %s no fire seen, actual none expected %h", t, e);
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired, actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end
endmodule